// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a blocking, direct-mapped cache placed between a processor request port and a slower memory that moves one 32-bit word per handshake. Reads that hit are answered from the line storage without touching memory. Reads that miss fetch the whole eight-word line, one word at a time from word 0 upward. The requested word is handed to the processor in the same cycle it arrives, while the rest of the line keeps loading. Every write is sent to memory. A write that hits also merges its enabled bytes into the cached word. A write that misses leaves the cache as it was.

The controller takes one request at a time. A request is accepted on a rising clock edge where `cpu_ready` is high and `cpu_rd` or `cpu_wr` is high; a write wins if both are set. The controller is a four-state machine:

- `S_IDLE`: ready; an accepted request moves it to `S_LOOKUP`.
- `S_LOOKUP`: one cycle of tag compare. From here:
  - a read hit returns its data and goes back to `S_IDLE`;
  - a read miss invalidates the line and goes to `S_FILL`;
  - any write goes to `S_WRITE`.
- `S_FILL`: requests the eight words of the line. After the acknowledge of word 7 it goes back to `S_IDLE`.
- `S_WRITE`: posts one memory write and goes back to `S_IDLE` on its acknowledge.

Top module: `dm_wt_cache`

## Requirements
- R1: A CPU address is split into tag = bits [23:13], line index = bits [12:5], word select = bits [4:2] and byte select = bits [1:0]. Addresses that differ only in word or byte bits use the same line.
- R2: After reset, every line is invalid, `cpu_ready` is 1, `mem_req` is 0 and `cpu_rvalid` is 0. The first read of any line after reset misses.
- R3: On a read hit, `cpu_rvalid` is 1 with the cached word on `cpu_rdata` in the cycle right after the acceptance edge. No memory request is made.
- R4: On a read miss, exactly eight memory reads (`mem_we` = 0) are made. Their addresses are the line base with word select 0, 1, …, 7 in that order, and `mem_addr[1:0]` = 0.
- R5: On a read miss, the requested word appears on `cpu_rdata` with `cpu_rvalid` = 1 in the same cycle that `mem_ack` returns that word. The remaining words of the line are still fetched after it.
- R6: A line becomes valid only once its eighth word has been written. After that, reads of any word of the line hit.
- R7: Each accepted write produces exactly one memory write with `mem_we` = 1. `mem_addr` equals the CPU byte address, and `mem_wdata` and `mem_be` equal the CPU data and byte enables. Enable bit i covers data bits 8i+7..8i.
- R8: A write hit merges the enabled bytes into the cached word. A later read hit returns the merged word.
- R9: A write miss makes no memory read and allocates no line. A later read of that line misses.
- R10: `cpu_ready` stays 0 from the acceptance edge until the fill or memory write completes. Strobes presented while it is 0 are ignored.
- R11: Once `mem_req` is raised, it stays 1 with `mem_addr` and `mem_we` unchanged until a cycle with `mem_ack` = 1.
- R12: Two addresses with the same index and different tags evict each other, so alternating reads of them both miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 24 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_rvalid | output | 1 | Read data valid this cycle |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
A wrong valid bit or stored tag shows up on the very next read of that line. It appears either as a spurious hit returning stale data one cycle after acceptance, or as eight unexpected memory reads where none were due. A fill counter that is off shows up within the same fill: the word addresses leave ascending order, or the load-through data arrives with a different acknowledge count than the word index predicts. A bad write merge stays hidden until the word is read back as a hit, so every write hit in the bench is followed by such a read.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int BSEL_W = $clog2(BE_W);

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRITE,
        S_FILL
    } ctl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int NUM_LINES = 256,
    parameter int TAG_W     = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] lk_idx,
    input  logic [TAG_W-1:0]             lk_tag,
    input  logic                         set_en,
    input  logic                         clr_en,
    output logic                         hit
);
    localparam int IDX_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_mem [NUM_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[lk_idx] <= 1'b1;
        end else if (clr_en) begin
            valid_q[lk_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_mem[lk_idx] <= lk_tag;
        end
    end

    assign hit = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);

    // R6: a line finished by the fill must look up as a hit straight after
    assert_hit_after_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> hit);

    assert_set_clr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));

    logic unused_idx_w;
    assign unused_idx_w = (IDX_W > 0);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int DEPTH_W = 11
) (
    input  logic               clk,
    input  logic [DEPTH_W-1:0] raddr,
    output logic [DATA_W-1:0]  rdata,
    input  logic               we,
    input  logic [DEPTH_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BE_W-1:0]    wbe
);
    localparam int DEPTH = 2 ** DEPTH_W;

    logic [DATA_W-1:0] word_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wbe[b]) begin
                    word_mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    assign rdata = word_mem[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 3,
    parameter int TAG_W  = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [BE_W-1:0]           cpu_be,
    output logic                      cpu_ready,
    output logic                      cpu_rvalid,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic [BE_W-1:0]           mem_be,
    input  logic [DATA_W-1:0]         mem_rdata,
    input  logic                      mem_ack,
    output logic [IDX_W-1:0]          lk_idx,
    output logic [TAG_W-1:0]          lk_tag,
    input  logic                      hit,
    output logic                      tag_set,
    output logic                      tag_clr,
    output logic [IDX_W+WSEL_W-1:0]   ds_raddr,
    input  logic [DATA_W-1:0]         ds_rdata,
    output logic                      ds_we,
    output logic [IDX_W+WSEL_W-1:0]   ds_waddr,
    output logic [DATA_W-1:0]         ds_wdata,
    output logic [BE_W-1:0]           ds_wbe
);
    localparam logic [WSEL_W-1:0] LAST_WORD = '1;

    ctl_state_t state, state_nx;

    logic [ADDR_W-1:0] op_addr;
    logic              op_wr;
    logic [DATA_W-1:0] op_wdata;
    logic [BE_W-1:0]   op_be;
    logic [WSEL_W-1:0] fill_cnt;
    logic [WSEL_W-1:0] op_word;
    logic              accept;

    assign accept  = (state == S_IDLE) && (cpu_rd || cpu_wr);
    assign lk_idx  = op_addr[BSEL_W+WSEL_W +: IDX_W];
    assign lk_tag  = op_addr[ADDR_W-1 -: TAG_W];
    assign op_word = op_addr[BSEL_W +: WSEL_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept) state_nx = S_LOOKUP;
            S_LOOKUP: begin
                if (op_wr)     state_nx = S_WRITE;
                else if (!hit) state_nx = S_FILL;
                else           state_nx = S_IDLE;
            end
            S_WRITE:  if (mem_ack) state_nx = S_IDLE;
            S_FILL:   if (mem_ack && (fill_cnt == LAST_WORD)) state_nx = S_IDLE;
        endcase
    end

    // Request capture and fill counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_wr    <= 1'b0;
            op_wdata <= '0;
            op_be    <= '0;
            fill_cnt <= '0;
        end else begin
            if (accept) begin
                op_addr  <= cpu_addr;
                op_wr    <= cpu_wr;
                op_wdata <= cpu_wdata;
                op_be    <= cpu_be;
            end
            if (state == S_LOOKUP) begin
                fill_cnt <= '0;
            end else if ((state == S_FILL) && mem_ack) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    assign ds_raddr = {lk_idx, op_word};

    // Outputs
    always_comb begin
        cpu_ready  = 1'b0;
        cpu_rvalid = 1'b0;
        cpu_rdata  = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_be     = '0;
        tag_set    = 1'b0;
        tag_clr    = 1'b0;
        ds_we      = 1'b0;
        ds_waddr   = '0;
        ds_wdata   = '0;
        ds_wbe     = '0;
        unique case (state)
            S_IDLE: cpu_ready = 1'b1;
            S_LOOKUP: begin
                if (op_wr) begin
                    ds_we    = hit;
                    ds_waddr = {lk_idx, op_word};
                    ds_wdata = op_wdata;
                    ds_wbe   = op_be;
                end else if (hit) begin
                    cpu_rvalid = 1'b1;
                    cpu_rdata  = ds_rdata;
                end else begin
                    tag_clr = 1'b1;
                end
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = op_addr;
                mem_wdata = op_wdata;
                mem_be    = op_be;
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {lk_tag, lk_idx, fill_cnt, {BSEL_W{1'b0}}};
                ds_we    = mem_ack;
                ds_waddr = {lk_idx, fill_cnt};
                ds_wdata = mem_rdata;
                ds_wbe   = '1;
                tag_set  = mem_ack && (fill_cnt == LAST_WORD);
                if (mem_ack && (fill_cnt == op_word)) begin
                    cpu_rvalid = 1'b1;
                    cpu_rdata  = mem_rdata;
                end
            end
        endcase
    end

    assert_fill_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> (mem_req && !mem_we));

    assert_fill_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL && mem_ack && fill_cnt != LAST_WORD) |=>
        (mem_addr[BSEL_W +: WSEL_W] == WSEL_W'($past(mem_addr[BSEL_W +: WSEL_W]) + 1'b1)));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_write_goes_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOOKUP && op_wr) |=> (mem_req && mem_we));

    assert_ready_after_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL && mem_ack && fill_cnt == LAST_WORD) |=> cpu_ready);
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int NUM_LINES  = 256,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BSEL_W;

    logic [IDX_W-1:0]        lk_idx;
    logic [TAG_W-1:0]        lk_tag;
    logic                    hit, tag_set, tag_clr;
    logic [IDX_W+WSEL_W-1:0] ds_raddr, ds_waddr;
    logic [DATA_W-1:0]       ds_rdata, ds_wdata;
    logic                    ds_we;
    logic [BE_W-1:0]         ds_wbe;

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .WSEL_W (WSEL_W),
        .TAG_W  (TAG_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_be     (cpu_be),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .hit        (hit),
        .tag_set    (tag_set),
        .tag_clr    (tag_clr),
        .ds_raddr   (ds_raddr),
        .ds_rdata   (ds_rdata),
        .ds_we      (ds_we),
        .ds_waddr   (ds_waddr),
        .ds_wdata   (ds_wdata),
        .ds_wbe     (ds_wbe)
    );

    dmc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (lk_idx),
        .lk_tag (lk_tag),
        .set_en (tag_set),
        .clr_en (tag_clr),
        .hit    (hit)
    );

    dmc_data_store #(
        .DEPTH_W (IDX_W + WSEL_W)
    ) u_data (
        .clk   (clk),
        .raddr (ds_raddr),
        .rdata (ds_rdata),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .wbe   (ds_wbe)
    );

    // R5: read data is only offered from the line store (no memory traffic)
    // or in the cycle a memory read is acknowledged
    assert_rvalid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (!mem_req || (mem_ack && !mem_we)));
endmodule

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dm_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0, fails = 0;
    int rd_acks = 0, wr_acks = 0, acks_at_rv = 0, busy_viol = 0;
    bit rv_seen = 0;
    bit done = 0;
    int fill_next = 0;

    logic [31:0] shadow [int];
    logic [31:0] rd_q [$];
    logic [59:0] wr_q [$];
    bit          exp_v [256];
    logic [10:0] exp_t [256];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [21:0] wa);
        if (shadow.exists(int'(wa))) return shadow[int'(wa)];
        return 32'h5A00_0000 ^ ({10'd0, wa} * 32'h0001_9E37);
    endfunction

    function automatic logic [23:0] mk(input logic [10:0] t, input logic [7:0] i, input logic [2:0] w);
        return {t, i, w, 2'b00};
    endfunction

    // Memory responder: acknowledges each request after a short wait
    initial begin
        int wait_c;
        logic [59:0] e;
        logic [31:0] old, nw;
        wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_c = 0;
            end else if (mem_req) begin
                if (wait_c < 2) wait_c++;
                else begin
                    wait_c = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wr_acks++;
                        if (wr_q.size() == 0) chk(0, "R7 unexpected memory write", {8'd0, mem_addr}, 0);
                        else begin
                            e = wr_q.pop_front();
                            chk(mem_addr == e[59:36], "R7 write address", {8'd0, mem_addr}, {8'd0, e[59:36]});
                            chk(mem_wdata == e[35:4], "R7 write data", mem_wdata, e[35:4]);
                            chk(mem_be == e[3:0], "R7 write byte enables", {28'd0, mem_be}, {28'd0, e[3:0]});
                        end
                        old = mem_word(mem_addr[23:2]);
                        for (int b = 0; b < 4; b++) nw[b*8 +: 8] = mem_be[b] ? mem_wdata[b*8 +: 8] : old[b*8 +: 8];
                        shadow[int'(mem_addr[23:2])] = nw;
                    end else begin
                        rd_acks++;
                        mem_rdata = mem_word(mem_addr[23:2]);
                        chk(int'(mem_addr[4:2]) == fill_next && mem_addr[1:0] == 2'b00,
                            "R4 fill word order", {29'd0, mem_addr[4:2]}, fill_next);
                        fill_next = (fill_next + 1) % 8;
                    end
                end
            end
        end
    end

    // Monitor: pops expected read data as results appear
    initial begin
        logic [31:0] e;
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && cpu_ready && mem_req) busy_viol++;
            if (rst_n && cpu_rvalid) begin
                if (rd_q.size() == 0) chk(0, "R3 unexpected read data", cpu_rdata, 0);
                else begin
                    e = rd_q.pop_front();
                    chk(cpu_rdata == e, "R3/R5 read data", cpu_rdata, e);
                    rv_seen = 1;
                    acks_at_rv = rd_acks;
                end
            end
        end
    end

    task automatic cpu_read(input logic [23:0] a, input bit stray);
        int idx, r0, w0, busy;
        bit miss;
        idx = int'(a[12:5]);
        miss = !exp_v[idx] || (exp_t[idx] != a[23:13]);
        while (!cpu_ready) @(negedge clk);
        rd_q.push_back(mem_word(a[23:2]));
        r0 = rd_acks; w0 = wr_acks; rv_seen = 0;
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        if (!miss) begin
            #5;
            chk(cpu_rvalid === 1'b1, "R3 hit data one cycle after accept", {31'd0, cpu_rvalid}, 1);
        end
        busy = 0;
        while (!cpu_ready) begin
            busy++;
            cpu_wr = stray && (busy < 4);
            cpu_addr = stray ? 24'hFFFFFC : a;
            @(negedge clk);
        end
        cpu_wr = 1'b0;
        chk(rv_seen, "R3/R5 read returned data", {31'd0, rv_seen}, 1);
        if (miss) begin
            chk(rd_acks - r0 == 8, "R4 eight-word fill on miss", rd_acks - r0, 8);
            chk(acks_at_rv - r0 == int'(a[4:2]) + 1, "R5 load-through at requested word",
                acks_at_rv - r0, int'(a[4:2]) + 1);
            exp_v[idx] = 1'b1;
            exp_t[idx] = a[23:13];
        end else begin
            chk(rd_acks == r0, "R3/R6 hit makes no memory read", rd_acks - r0, 0);
        end
        if (stray) begin
            chk(wr_acks == w0, "R10 strobe while busy ignored", wr_acks - w0, 0);
            chk(busy >= 9, "R10 ready low during fill", busy, 9);
        end
    endtask

    task automatic cpu_write(input logic [23:0] a, input logic [31:0] d, input logic [3:0] be);
        int r0, w0;
        while (!cpu_ready) @(negedge clk);
        wr_q.push_back({a, d, be});
        r0 = rd_acks; w0 = wr_acks;
        cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        do @(negedge clk); while (!cpu_ready);
        chk(wr_acks - w0 == 1, "R7 one memory write per store", wr_acks - w0, 1);
        chk(rd_acks == r0, "R9 store makes no memory read", rd_acks - r0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) exp_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        #5;
        chk(cpu_ready === 1'b1, "R2 ready after reset", {31'd0, cpu_ready}, 1);
        chk(mem_req === 1'b0, "R2 no memory request in reset", {31'd0, mem_req}, 0);
        chk(cpu_rvalid === 1'b0, "R2 no read data in reset", {31'd0, cpu_rvalid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [23:0] a_, b_, c_;
        int r0;
        do_reset();
        a_ = mk(11'h155, 8'h2A, 3'd5);
        b_ = mk(11'h0AA, 8'h10, 3'd2);
        c_ = mk(11'h7FF, 8'h2A, 3'd7);

        // R4 R5 R10: read miss with stray strobes during the fill
        cpu_read(a_, 1'b1);
        // R3 R6 R1: hits on the same line, other words and byte offsets
        cpu_read(a_, 1'b0);
        cpu_read(mk(11'h155, 8'h2A, 3'd0), 1'b0);
        cpu_read(mk(11'h155, 8'h2A, 3'd7) | 24'd3, 1'b0);
        r0 = rd_acks;
        cpu_read(a_ | 24'd2, 1'b0);
        chk(rd_acks == r0, "R1 byte bits select same line", rd_acks - r0, 0);

        // R7 R8: write hit with partial byte enables, then read back
        cpu_write(a_ | 24'd1, 32'hDEADBEEF, 4'b0101);
        cpu_read(a_, 1'b0);
        cpu_write(mk(11'h155, 8'h2A, 3'd0), 32'h1234_5678, 4'b1000);
        cpu_read(mk(11'h155, 8'h2A, 3'd0), 1'b0);

        // R9: write miss does not allocate
        cpu_write(b_, 32'hCAFE_F00D, 4'hF);
        r0 = rd_acks;
        cpu_read(b_, 1'b0);
        chk(rd_acks - r0 == 8, "R9 read after write miss misses", rd_acks - r0, 8);
        cpu_read(b_, 1'b0);

        // R12: same index, different tag evicts; load-through of word 7
        cpu_read(c_, 1'b0);
        r0 = rd_acks;
        cpu_read(a_, 1'b0);
        chk(rd_acks - r0 == 8, "R12 conflicting tag evicted line", rd_acks - r0, 8);

        // R2: reset invalidates all lines
        do_reset();
        r0 = rd_acks;
        cpu_read(a_, 1'b0);
        chk(rd_acks - r0 == 8, "R2 first read after reset misses", rd_acks - r0, 8);

        // Mixed traffic over several lines and tags
        for (int i = 0; i < 24; i++) begin
            logic [23:0] x;
            x = mk(11'(i % 3), 8'((i * 37) % 5), 3'(i * 3));
            if (i % 4 == 3) cpu_write(x, 32'h0F0F_0000 + i, 4'(i));
            else cpu_read(x, 1'b0);
        end

        chk(busy_viol == 0, "R10 ready never high with request pending", busy_viol, 0);
        chk(rd_q.size() == 0 && wr_q.size() == 0, "R3/R7 all expected results seen",
            rd_q.size() + wr_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule